// File: doc/BRIEF.md
# Pipelined Burst-of-Two SRAM Read Path

This block models the read side of a synchronous pipelined SRAM whose data leaves on both halves of the output clock. Address and control are registered on the rising edge of the input clock. A read command loads the address into a read address register. The address's lowest bit seeds a one-bit burst counter, and that counter picks the order in which the two words of an aligned pair are returned.

The double-rate output is modelled as two output slots per input clock cycle. `q_rise_o` carries the word for the rising output edge and `q_fall_o` carries the word for the complementary edge. A single `vld_o` flag covers both slots of a burst. A burst cannot be cut short. Commands may arrive on every cycle, so bursts stream with no idle slot between them. Commands already accepted are still delivered after the command stream stops.

The array holds 2^ADDR_W words of DATA_W bits. It is loaded at start-up with a computed pattern that the bench can reproduce. A parameter decides whether the idle data bus keeps the last word or drives a fixed idle word.

Top module: `rdp_burst_read`

## Requirements
- R1: A read command is accepted at a rising clock edge only when `ld_n_i` is 0 and `rw_i` is 1. Every other combination leaves `vld_o` low two edges later.
- R2: The burst of a command accepted at edge n is presented on the outputs just after edge n+1, so it is visible two edges after the command was applied.
- R3: The array word at address a starts out as (a*5 + INIT_SEED) mod 2^DATA_W. The rising-edge slot `q_rise_o` carries the word at the commanded address A.
- R4: The falling-edge slot `q_fall_o` carries the word at A with bit 0 advanced by one, wrapping within the pair. A = 2k gives the order 2k, 2k+1, and A = 2k+1 gives the order 2k+1, 2k.
- R5: Reads on consecutive edges produce bursts on consecutive cycles, with `vld_o` high throughout and no gap.
- R6: A burst already accepted when commands stop is still delivered in full. `vld_o` then falls.
- R7: `vld_o` is high for exactly one cycle, covering both slots, per accepted command, and is low otherwise.
- R8: With IDLE_MODE fixed, both slots show IDLE_WORD whenever `vld_o` is low. With IDLE_MODE hold, both slots keep their last value while `vld_o` is low.
- R9: A synchronous reset drops any accepted command, clears `vld_o` and sets both slots to IDLE_WORD. It leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all sampling on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ld_n_i | input | 1 | Load strobe, active low |
| rw_i | input | 1 | Read/write select, 1 = read |
| addr_i | input | ADDR_W | Word address of the command |
| q_rise_o | output | DATA_W | Word for the rising output edge (first of the burst) |
| q_fall_o | output | DATA_W | Word for the complementary output edge (second of the burst) |
| vld_o | output | 1 | High while both slots carry a burst |

## Verification
Two events can fall on the same edge: the output stage issues the second word of one burst, and a new command is accepted for the following burst. The bench provokes this by sweeping every address as an unbroken stream of reads. It then checks each cycle's pair against the arithmetic fill formula, with no slot gap and no carry-over between neighbouring bursts. Reset is also applied while a command sits in the pipeline. That burst must vanish, and a later read of the same address must return the original word.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

   typedef enum bit {
      RDP_IDLE_FIXED = 1'b0,
      RDP_IDLE_HOLD  = 1'b1
   } rdp_idle_e;

   // start-up content of one array word, before truncation to the data width
   function automatic logic [31:0] rdp_fill(input int unsigned addr, input int unsigned seed);
      return 32'(addr * 5 + seed);
   endfunction

endpackage

// File: rtl/rdp_cmd_reg.sv
module rdp_cmd_reg #(
   parameter int ADDR_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_n_i,
   input  logic              rw_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              cmd_vld_o,
   output logic [ADDR_W-1:0] cmd_addr_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cmd_vld_o  <= 1'b0;
         cmd_addr_o <= '0;
      end else begin
         cmd_vld_o  <= ~ld_n_i & rw_i;
         cmd_addr_o <= addr_i;
      end
   end

endmodule

// File: rtl/rdp_pair_array.sv
module rdp_pair_array #(
   parameter int          ADDR_W    = 10,
   parameter int          DATA_W    = 18,
   parameter int unsigned INIT_SEED = 32'h155
) (
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] word_o [2]
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = DATA_W'(rdp_pkg::rdp_fill(i, INIT_SEED));
      end
   end

   // one-bit burst counter seeded by the address LSB; slot s takes step s
   for (genvar s = 0; s < 2; s++) begin : g_slot
      logic              burst_bit;
      logic [ADDR_W-1:0] slot_addr;
      always_comb begin
         burst_bit = rd_addr_i[0] + 1'(s);
         slot_addr = {rd_addr_i[ADDR_W-1:1], burst_bit};
         word_o[s] = mem[slot_addr];
      end
   end

endmodule

// File: rtl/rdp_out_stage.sv
module rdp_out_stage #(
   parameter int                DATA_W    = 18,
   parameter rdp_pkg::rdp_idle_e IDLE_MODE = rdp_pkg::RDP_IDLE_FIXED,
   parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_i [2],
   output logic [DATA_W-1:0] q_rise_o,
   output logic [DATA_W-1:0] q_fall_o,
   output logic              vld_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) vld_o <= 1'b0;
      else       vld_o <= load_i;
   end

   if (IDLE_MODE == rdp_pkg::RDP_IDLE_HOLD) begin : g_hold
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            q_rise_o <= IDLE_WORD;
            q_fall_o <= IDLE_WORD;
         end else if (load_i) begin
            q_rise_o <= word_i[0];
            q_fall_o <= word_i[1];
         end
      end
   end else begin : g_fixed
      always_ff @(posedge clk_i) begin
         if (rst_i || !load_i) begin
            q_rise_o <= IDLE_WORD;
            q_fall_o <= IDLE_WORD;
         end else begin
            q_rise_o <= word_i[0];
            q_fall_o <= word_i[1];
         end
      end
   end

endmodule

// File: rtl/rdp_burst_read.sv
module rdp_burst_read #(
   parameter int                 ADDR_W    = 10,
   parameter int                 DATA_W    = 18,
   parameter int unsigned        INIT_SEED = 32'h155,
   parameter rdp_pkg::rdp_idle_e IDLE_MODE = rdp_pkg::RDP_IDLE_FIXED,
   parameter logic [DATA_W-1:0]  IDLE_WORD = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_n_i,
   input  logic              rw_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] q_rise_o,
   output logic [DATA_W-1:0] q_fall_o,
   output logic              vld_o
);

   localparam int MAX_ADDR_W = 16;

   if (ADDR_W < 2 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("rdp_burst_read: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("rdp_burst_read: DATA_W must be positive");
   end

   logic              cmd_vld;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] pair_word [2];

   rdp_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .ld_n_i    (ld_n_i),
      .rw_i      (rw_i),
      .addr_i    (addr_i),
      .cmd_vld_o (cmd_vld),
      .cmd_addr_o(cmd_addr)
   );

   rdp_pair_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_SEED(INIT_SEED)) u_arr (
      .rd_addr_i(cmd_addr),
      .word_o   (pair_word)
   );

   rdp_out_stage #(.DATA_W(DATA_W), .IDLE_MODE(IDLE_MODE), .IDLE_WORD(IDLE_WORD)) u_out (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (cmd_vld),
      .word_i  (pair_word),
      .q_rise_o(q_rise_o),
      .q_fall_o(q_fall_o),
      .vld_o   (vld_o)
   );

endmodule

// File: rtl/rdp_burst_read_chk.sv
module rdp_burst_read_chk #(
   parameter int                 DATA_W    = 18,
   parameter rdp_pkg::rdp_idle_e IDLE_MODE = rdp_pkg::RDP_IDLE_FIXED,
   parameter logic [DATA_W-1:0]  IDLE_WORD = '0
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              ld_n_i,
   input logic              rw_i,
   input logic              cmd_q,
   input logic              vld_o,
   input logic [DATA_W-1:0] q_rise_o,
   input logic [DATA_W-1:0] q_fall_o
);

   // R1
   cmd_accept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ld_n_i && rw_i) |=> cmd_q);

   // R1
   cmd_reject_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(!ld_n_i && rw_i) |=> !cmd_q);

   // R2
   burst_issue_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cmd_q |=> vld_o);

   // R7
   no_spurious_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !cmd_q |=> !vld_o);

   // R9
   reset_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (!vld_o && !cmd_q));

   if (IDLE_MODE == rdp_pkg::RDP_IDLE_HOLD) begin : g_hold_chk
      // R8
      idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         (!vld_o && !$past(rst_i)) |-> ($stable(q_rise_o) && $stable(q_fall_o)));
   end else begin : g_fixed_chk
      // R8
      idle_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         !vld_o |-> (q_rise_o == IDLE_WORD && q_fall_o == IDLE_WORD));
   end

endmodule

bind rdp_burst_read rdp_burst_read_chk #(
   .DATA_W   (DATA_W),
   .IDLE_MODE(IDLE_MODE),
   .IDLE_WORD(IDLE_WORD)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .ld_n_i  (ld_n_i),
   .rw_i    (rw_i),
   .cmd_q   (cmd_vld),
   .vld_o   (vld_o),
   .q_rise_o(q_rise_o),
   .q_fall_o(q_fall_o)
);

// File: tb/test_rdp_burst_read.sv
module test_rdp_burst_read;

   localparam int              AW     = 10;
   localparam int              DW     = 18;
   localparam int unsigned     SEED   = 32'h155;
   localparam logic [DW-1:0]   IDLE_A = 18'h2A5A5;
   localparam logic [DW-1:0]   IDLE_B = 18'h00000;

   logic          clk = 1'b0;
   logic          rst, ld_n, rw;
   logic [AW-1:0] addr;
   logic [DW-1:0] a_r, a_f, b_r, b_f;
   logic          a_v, b_v;

   int vectors = 0;
   int fails   = 0;

   // bench model of the outputs after the most recent edge
   logic          m_cmd, m_vld;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_r, m_f, h_r, h_f;

   always #5 clk = ~clk;

   rdp_burst_read #(.ADDR_W(AW), .DATA_W(DW), .INIT_SEED(SEED),
                    .IDLE_MODE(rdp_pkg::RDP_IDLE_FIXED), .IDLE_WORD(IDLE_A)) i_rdp_burst_read (
      .clk_i(clk), .rst_i(rst), .ld_n_i(ld_n), .rw_i(rw), .addr_i(addr),
      .q_rise_o(a_r), .q_fall_o(a_f), .vld_o(a_v));

   rdp_burst_read #(.ADDR_W(AW), .DATA_W(DW), .INIT_SEED(SEED),
                    .IDLE_MODE(rdp_pkg::RDP_IDLE_HOLD), .IDLE_WORD(IDLE_B)) i_rdp_burst_read_hold (
      .clk_i(clk), .rst_i(rst), .ld_n_i(ld_n), .rw_i(rw), .addr_i(addr),
      .q_rise_o(b_r), .q_fall_o(b_f), .vld_o(b_v));

   function automatic logic [DW-1:0] fill(input logic [AW-1:0] a);
      return DW'(32'(a) * 5 + SEED);
   endfunction

   task automatic step(input logic s_ld_n, input logic s_rw, input logic [AW-1:0] s_addr,
                       input logic s_rst, input string tag);
      @(negedge clk);
      vectors++;
      if (a_v !== m_vld || b_v !== m_vld) begin
         fails++;
         $display("FAIL %s/R7 vld: actual %b/%b expected %b", tag, a_v, b_v, m_vld);
      end else if (a_r !== m_r || a_f !== m_f) begin
         fails++;
         $display("FAIL %s/R3/R4 fixed-idle slots: actual %h/%h expected %h/%h",
                  tag, a_r, a_f, m_r, m_f);
      end else if (b_r !== h_r || b_f !== h_f) begin
         fails++;
         $display("FAIL %s/R8 hold slots: actual %h/%h expected %h/%h", tag, b_r, b_f, h_r, h_f);
      end
      rst  = s_rst;
      ld_n = s_ld_n;
      rw   = s_rw;
      addr = s_addr;
      if (s_rst) begin
         m_cmd = 1'b0; m_vld = 1'b0;
         m_r = IDLE_A; m_f = IDLE_A; h_r = IDLE_B; h_f = IDLE_B;
      end else begin
         m_vld = m_cmd;
         if (m_cmd) begin
            m_r = fill(m_addr);
            m_f = fill({m_addr[AW-1:1], ~m_addr[0]});
            h_r = m_r; h_f = m_f;
         end else begin
            m_r = IDLE_A; m_f = IDLE_A;
         end
         m_cmd  = ~s_ld_n & s_rw;
         m_addr = s_addr;
      end
   endtask

   initial begin
      #(10 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; ld_n = 1'b1; rw = 1'b0; addr = '0;
      m_cmd = 1'b0; m_vld = 1'b0; m_addr = '0;
      m_r = IDLE_A; m_f = IDLE_A; h_r = IDLE_B; h_f = IDLE_B;
      // R9: reset state
      step(1, 0, 0, 1, "R9");
      step(1, 0, 0, 1, "R9");
      // R1: non-read encodings are ignored
      step(1, 1, 5, 0, "R1");
      step(1, 0, 6, 0, "R1");
      step(0, 0, 7, 0, "R1");
      step(1, 0, 0, 0, "R1");
      step(1, 0, 0, 0, "R1");
      // R2, R6: lone read then deselect
      step(0, 1, 10, 0, "R2");
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R6");
      // R4: odd address wraps within the pair
      step(0, 1, 11, 0, "R4");
      for (int i = 0; i < 2; i++) step(1, 0, 0, 0, "R4");
      // R5, R3: every address as an unbroken read stream
      for (int i = 0; i < (1 << AW); i++) step(0, 1, AW'(i), 0, "R5");
      // R6, R8: stream stops, last burst completes, then idle
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R8");
      // R9: reset with commands in flight, array kept
      step(0, 1, 20, 0, "R9");
      step(0, 1, 21, 0, "R9");
      step(1, 0, 0, 1, "R9");
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R9");
      step(0, 1, 20, 0, "R3");
      step(0, 1, 21, 0, "R3");
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R6");
      // R7: mixed command encodings
      for (int i = 0; i < 256; i++) begin
         logic [7:0] k = 8'(i);
         step(k[0], k[1] | k[2], AW'(i * 7), 0, "R7");
      end
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R7");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule